// File: doc/BRIEF.md
# Windowed Frequency Meter with Limit Check

This block measures how fast an on-chip clock runs. A PLL output or a ring built from a delay line are typical sources. The meter opens a gate for a programmed number of reference-clock cycles. While the gate is open it counts rising edges of the measured clock, which is asynchronous to the reference and may be many times faster. When the gate has closed, the count is brought back into the reference domain. There it is published as a full binary word, together with a single pass bit that tells whether the word lies inside a programmed limit window.

Software or a test sequencer sets the window length and the two limits, then pulses a start strobe. A one-cycle completion pulse tells it that the word and the pass bit are ready. To demand an exact count, the lower and upper limits are set to the same value. A count that reaches the all-ones value of the counter is treated as overflow and always fails.

Top module: `freq_window_meter`

## Requirements
- R1: While either reset is asserted and after its release, busy, done, result and pass are all 0 until the first measurement completes.
- R2: A start accepted while idle opens the gate for max(win_len,1) reference cycles. The result equals the number of measured-clock rising edges that see the synchronised gate open. For a measured clock exactly K times the reference frequency, this is K*max(win_len,1).
- R3: Start is ignored while busy is 1. Window length and limits are captured when a start is accepted, and later changes to them have no effect on that measurement.
- R4: done is high for exactly one reference cycle per measurement. result and pass change only in that cycle and hold until the next done.
- R5: pass is 1 exactly when lim_lo <= result <= lim_hi, both bounds inclusive.
- R6: With lim_lo equal to lim_hi, pass is 1 only for a count that matches that value in every bit.
- R7: The counter stops at 2^CW-1 instead of wrapping. A result of 2^CW-1 always gives pass 0, even when the limits include it.
- R8: busy is 0 in the done cycle, so a start sampled at the end of the done cycle begins the next measurement back to back.
- R9: busy rises in the cycle after an accepted start and stays high until the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_ref_n | input | 1 | Active-low reset, reference domain |
| clk_meas | input | 1 | Clock under measurement |
| rst_meas_n | input | 1 | Active-low reset, measured domain |
| start | input | 1 | Request a measurement (sampled when idle) |
| win_len | input | GW | Gate length in reference cycles (0 acts as 1) |
| lim_lo | input | CW | Lowest passing count |
| lim_hi | input | CW | Highest passing count |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle strobe: result and pass are new |
| result | output | CW | Counted measured-clock edges |
| pass | output | 1 | Count inside the limit window and not saturated |

## Verification
Two events can meet in one reference cycle: a result landing with its done strobe, and the acceptance of the next start. The bench holds start high across a completion and then expects two scoreboard results. It also checks that busy is low in the done cycle and high one cycle later. A second collision, a start repeated mid-measurement with new window and limit values, is judged by a single completion that carries the values of the first request. The bench also checks that no extra done appears in a quiet stretch afterwards.

// File: rtl/fwm_pkg.sv
`timescale 1ps/1ps
package fwm_pkg;

  localparam int FWM_ARG_W = 32;

  typedef enum logic [1:0] {
    FWM_IDLE  = 2'd0,
    FWM_OPEN  = 2'd1,
    FWM_DRAIN = 2'd2
  } fwm_state_e;

  // Effective gate length: a programmed zero behaves like one cycle.
  function automatic logic [FWM_ARG_W-1:0] fwm_gate_len(input logic [FWM_ARG_W-1:0] n);
    return (n == '0) ? FWM_ARG_W'(1) : n;
  endfunction

  // All-ones count in a counter of the given width.
  function automatic logic fwm_saturated(input logic [FWM_ARG_W-1:0] cnt, input int width);
    logic [FWM_ARG_W-1:0] top;
    top = (FWM_ARG_W'(1) << width) - FWM_ARG_W'(1);
    return cnt == top;
  endfunction

  // Inclusive window test, overridden by saturation.
  function automatic logic fwm_verdict(input logic [FWM_ARG_W-1:0] cnt,
                                       input logic [FWM_ARG_W-1:0] lo,
                                       input logic [FWM_ARG_W-1:0] hi,
                                       input logic                 sat);
    return !sat && (cnt >= lo) && (cnt <= hi);
  endfunction

endpackage

// File: rtl/fwm_sync.sv
`timescale 1ps/1ps
module fwm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fwm_edge_count.sv
`timescale 1ps/1ps
module fwm_edge_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_s,
  output logic [CW-1:0] hold,
  output logic          req_tgl,
  output logic          win_open,
  output logic          win_close
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic          gate_d;
  logic [CW-1:0] cnt;

  assign win_open  = gate_s & ~gate_d;
  assign win_close = ~gate_s & gate_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d  <= 1'b0;
      cnt     <= '0;
      hold    <= '0;
      req_tgl <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (win_open) begin
        cnt <= CW'(1);                     // this edge already sees the gate open
      end else if (gate_s && cnt != CNT_TOP) begin
        cnt <= cnt + CW'(1);
      end
      if (win_close) begin
        hold    <= cnt;                    // frozen until the next close
        req_tgl <= ~req_tgl;
      end
    end
  end
endmodule

// File: rtl/fwm_window_ctrl.sv
`timescale 1ps/1ps
module fwm_window_ctrl
  import fwm_pkg::*;
#(
  parameter int CW = 16,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [GW-1:0] win_len,
  input  logic [CW-1:0] lim_lo,
  input  logic [CW-1:0] lim_hi,
  input  logic          req_tgl_s,
  input  logic [CW-1:0] hold_cnt,
  output logic          gate,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] result,
  output logic          pass,
  output logic          accept,
  output logic          land,
  output logic [CW-1:0] lo_q,
  output logic [CW-1:0] hi_q
);
  fwm_state_e    state;
  logic [GW-1:0] remain;
  logic          req_seen;
  logic [GW-1:0] first_remain;
  logic          verdict;

  assign accept = (state == FWM_IDLE) && start;
  assign land   = (state == FWM_DRAIN) && (req_tgl_s != req_seen);
  assign busy   = (state != FWM_IDLE);

  assign first_remain = GW'(fwm_gate_len(FWM_ARG_W'(win_len)) - FWM_ARG_W'(1));
  assign verdict = fwm_verdict(FWM_ARG_W'(hold_cnt), FWM_ARG_W'(lo_q), FWM_ARG_W'(hi_q),
                               fwm_saturated(FWM_ARG_W'(hold_cnt), CW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FWM_IDLE;
      remain   <= '0;
      gate     <= 1'b0;
      req_seen <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      done     <= 1'b0;
      result   <= '0;
      pass     <= 1'b0;
    end else begin
      req_seen <= req_tgl_s;
      done     <= 1'b0;
      unique case (state)
        FWM_IDLE: begin
          if (accept) begin
            remain <= first_remain;
            lo_q   <= lim_lo;
            hi_q   <= lim_hi;
            gate   <= 1'b1;
            state  <= FWM_OPEN;
          end
        end
        FWM_OPEN: begin
          if (remain == '0) begin
            gate  <= 1'b0;
            state <= FWM_DRAIN;
          end else begin
            remain <= remain - GW'(1);
          end
        end
        FWM_DRAIN: begin
          if (land) begin
            result <= hold_cnt;
            pass   <= verdict;
            done   <= 1'b1;
            state  <= FWM_IDLE;
          end
        end
        default: state <= FWM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/freq_window_meter.sv
`timescale 1ps/1ps
module freq_window_meter #(
  parameter int CW = 16,
  parameter int GW = 16
) (
  input  logic          clk_ref,
  input  logic          rst_ref_n,
  input  logic          clk_meas,
  input  logic          rst_meas_n,
  input  logic          start,
  input  logic [GW-1:0] win_len,
  input  logic [CW-1:0] lim_lo,
  input  logic [CW-1:0] lim_hi,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] result,
  output logic          pass
);
  logic          gate_ref;
  logic          gate_meas;
  logic          req_tgl;
  logic          req_tgl_s;
  logic [CW-1:0] hold_cnt;
  logic          ev_accept;
  logic          ev_land;
  logic          ev_win_open;
  logic          ev_win_close;
  logic [CW-1:0] lo_q;
  logic [CW-1:0] hi_q;

  fwm_window_ctrl #(.CW(CW), .GW(GW)) u_ctrl (
    .clk(clk_ref), .rst_n(rst_ref_n), .start(start), .win_len(win_len),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .req_tgl_s(req_tgl_s), .hold_cnt(hold_cnt),
    .gate(gate_ref), .busy(busy), .done(done), .result(result), .pass(pass),
    .accept(ev_accept), .land(ev_land), .lo_q(lo_q), .hi_q(hi_q)
  );

  fwm_sync #(.W(1)) u_gate_sync (
    .clk(clk_meas), .rst_n(rst_meas_n), .d(gate_ref), .q(gate_meas)
  );

  fwm_edge_count #(.CW(CW)) u_count (
    .clk(clk_meas), .rst_n(rst_meas_n), .gate_s(gate_meas), .hold(hold_cnt),
    .req_tgl(req_tgl), .win_open(ev_win_open), .win_close(ev_win_close)
  );

  fwm_sync #(.W(1)) u_req_sync (
    .clk(clk_ref), .rst_n(rst_ref_n), .d(req_tgl), .q(req_tgl_s)
  );
endmodule

// File: rtl/fwm_checker.sv
`timescale 1ps/1ps
module fwm_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          gate,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] result,
  input logic          pass,
  input logic [CW-1:0] lo_q,
  input logic [CW-1:0] hi_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                            // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(pass)));              // R4
  AST_PASS_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (result >= lo_q && result <= hi_q));     // R5
  AST_SAT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&result)) |-> !pass);                             // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                            // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));                                      // R9
  AST_GATE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> busy);                                             // R2
  AST_LIMITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(lo_q) && $stable(hi_q)));      // R3
endmodule

bind freq_window_meter fwm_checker #(.CW(CW)) u_fwm_checker (
  .clk(clk_ref), .rst_n(rst_ref_n), .start(start), .gate(gate_ref), .busy(busy),
  .done(done), .result(result), .pass(pass), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/sim_freq_window_meter.sv
`timescale 1ps/1ps
module sim_freq_window_meter;
  localparam int CW    = 10;
  localparam int GW    = 12;
  localparam int RATIO = 4;              // measured clock runs 4x the reference
  localparam int CTOP  = (1 << CW) - 1;

  logic          clk_ref = 1'b0;
  logic          clk_meas = 1'b0;
  logic          rst_ref_n = 1'b0;
  logic          rst_meas_n = 1'b0;
  logic          start = 1'b0;
  logic [GW-1:0] win_len = '0;
  logic [CW-1:0] lim_lo = '0;
  logic [CW-1:0] lim_hi = '0;
  logic          busy, done, pass;
  logic [CW-1:0] result;

  int checks = 0;
  int errors = 0;
  int ndone  = 0;
  int npush  = 0;
  int q_cnt[$];
  bit q_pass[$];
  string q_tag[$];

  freq_window_meter #(.CW(CW), .GW(GW)) u0 (
    .clk_ref(clk_ref), .rst_ref_n(rst_ref_n), .clk_meas(clk_meas), .rst_meas_n(rst_meas_n),
    .start(start), .win_len(win_len), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .busy(busy), .done(done), .result(result), .pass(pass)
  );

  always #2000 clk_ref = ~clk_ref;                 // 250 MHz
  initial begin
    #300;
    forever #500 clk_meas = ~clk_meas;             // 1 GHz, edges clear of reference edges
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_count(input int n);
    int c;
    c = ((n == 0) ? 1 : n) * RATIO;
    return (c > CTOP) ? CTOP : c;
  endfunction

  function automatic bit model_pass(input int c, input int lo, input int hi);
    return (c != CTOP) && (c >= lo) && (c <= hi);
  endfunction

  task automatic expect_item(input int n, input int lo, input int hi, input string tag);
    int c;
    c = model_count(n);
    q_cnt.push_back(c);
    q_pass.push_back(model_pass(c, lo, hi));
    q_tag.push_back(tag);
    npush++;
  endtask

  task automatic wait_done();
    int guard = 0;
    @(negedge clk_ref);
    while (!done && guard < 5000) begin
      @(negedge clk_ref);
      guard++;
    end
  endtask

  task automatic measure(input int n, input int lo, input int hi, input string tag);
    expect_item(n, lo, hi, tag);
    @(negedge clk_ref);
    win_len = GW'(n);
    lim_lo  = CW'(lo);
    lim_hi  = CW'(hi);
    start   = 1'b1;
    @(negedge clk_ref);
    start   = 1'b0;
    wait_done();
  endtask

  // Monitor: compare each completion against the scoreboard head.
  always @(negedge clk_ref) begin
    if (rst_ref_n && done) begin
      ndone++;
      if (q_cnt.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R3 unexpected done actual=%0d expected=none", result);
      end else begin
        int c;
        bit p;
        string t;
        c = q_cnt.pop_front();
        p = q_pass.pop_front();
        t = q_tag.pop_front();
        check({t, " count"}, int'(result), c);
        check({t, " pass"}, int'(pass), int'(p));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_ref);
    check("R1 busy in reset", int'(busy), 0);
    rst_meas_n = 1'b1;
    rst_ref_n  = 1'b1;
    @(negedge clk_ref);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);
    check("R1 pass", int'(pass), 0);

    measure(8, 30, 34, "R2 inside");
    measure(8, 33, 40, "R5 below lower");
    measure(20, 0, 79, "R5 above upper");
    measure(8, 32, 40, "R5 on lower bound");
    measure(0, 4, 4, "R2 zero length");
    measure(255, 1020, 1020, "R6 exact match");
    measure(255, 1019, 1019, "R6 one off");
    measure(300, 0, CTOP, "R7 saturated");
    measure(3, 12, 12, "R7 clears after overflow");

    // R9: busy follows an accepted start by one cycle
    expect_item(10, 0, 100, "R3 first request kept");
    @(negedge clk_ref);
    win_len = GW'(10); lim_lo = '0; lim_hi = CW'(100); start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    check("R9 busy after start", int'(busy), 1);
    repeat (3) @(negedge clk_ref);
    win_len = GW'(50); lim_hi = CW'(5); start = 1'b1;   // ignored, not captured
    repeat (2) @(negedge clk_ref);
    start = 1'b0;
    wait_done();
    repeat (80) @(negedge clk_ref);
    check("R3 completions", ndone, npush);

    // R8: start held high across a completion restarts at once
    expect_item(6, 20, 30, "R8 first");
    expect_item(6, 24, 24, "R8 second");
    @(negedge clk_ref);
    win_len = GW'(6); lim_lo = CW'(24); lim_hi = CW'(24); start = 1'b1;
    wait_done();
    check("R8 idle in done cycle", int'(busy), 0);
    @(negedge clk_ref);
    check("R8 restarted", int'(busy), 1);
    start = 1'b0;
    wait_done();
    repeat (40) @(negedge clk_ref);
    check("R4 all results seen", ndone, npush);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule